// File: doc/BRIEF.md
# UART auto-baud rate detector

This block measures the bit period of a 0x55 synchronisation character that arrives on an asynchronous receive line. From that measurement it produces a divisor that a baud-rate generator can load. Software, or a controlling state machine, pulses `start` to arm a run. The block then waits for the falling edge of the start bit. It opens a measurement window at the next rising edge and closes it at the fifth rising edge, which is the edge into the stop bit. A 16-bit counter advances on a prescaled tick during the window.

The tick rate is eight times slower than the baud generator's usual base clock. For that reason the final count is the average single-bit period expressed in base-clock units, not the full character time. `sel16` and `selhs` choose the base clock, and the full 16-bit counter is used whatever `sel16` says.

At the closing edge the run-enable drops and the done flag rises in the same cycle. The done flag stays high until the receive-data read strobe. While a run is active, `rx_hold` keeps the normal receiver idle. If the count would pass all-ones, it sticks at all-ones and a sticky overflow flag is raised.

Top module: `uart_autobaud`

## Requirements
- R1: `rx_in` passes through a two-flop synchroniser that idles high. Counting starts at the first rising edge that follows a falling edge seen after `start`, and the divisor is loaded with 1 at that edge.
- R2: The tick divides the system clock by a factor chosen by `{sel16,selhs}`: 2'b00 gives 512, 2'b01 gives 128, 2'b10 gives 128 and 2'b11 gives 32. For a 0x55 frame with bit period B clocks, the final divisor is within ±1 of B·8 divided by that factor.
- R3: The window closes on the fifth rising edge. The final divisor equals 1 plus the number of whole tick periods completed inside the window, and the divisor does not change while no run is active.
- R4: In the cycle the fifth rising edge is detected, `en` falls and `done` rises together.
- R5: `done` stays high until a cycle with `data_rd` high. When completion and `data_rd` fall in the same cycle, completion wins and `done` is high afterwards.
- R6: `rx_hold` is high exactly while `en` is high.
- R7: If the counter is at all-ones and another tick arrives, the divisor stays at all-ones and `ovf` is set. `ovf` stays set until the next `start`.
- R8: A `start` pulse in any state clears the divisor, `done` and `ovf`, raises `en`, and begins a new measurement.
- R9: The divisor counts past 255 across both bytes even when `sel16` is 0.
- R10: After synchronous reset, `en`, `done`, `rx_hold` and `ovf` are 0 and the divisor is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous receive line, idle high |
| start | input | 1 | One-cycle pulse that arms a new measurement |
| data_rd | input | 1 | Receive-data read strobe; clears `done` |
| sel16 | input | 1 | 16-bit divisor mode select (affects tick rate only) |
| selhs | input | 1 | High-speed select (affects tick rate only) |
| divisor | output | CNT_W | Measured divisor, live during a run |
| ovf | output | 1 | Sticky counter overflow flag |
| done | output | 1 | Completion / receive-interrupt flag |
| en | output | 1 | Run enable; clears itself on completion |
| rx_hold | output | 1 | Holds the normal receiver idle during a run |

## Verification
The completion event, which sets `done`, can land in the same cycle as a `data_rd` strobe, which clears it. The bench provokes this by holding `data_rd` high across the whole tail of a frame. The fifth edge therefore coincides with a read, and the bench expects `done` to be high for exactly that one cycle and cleared the cycle after. A `start` pulse that lands mid-frame is also judged against the reference model: the frame's leftover edges must be treated as a fresh measurement.

// File: rtl/abd_pkg.sv
package abd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_FIRST,
    ST_MEAS
  } abd_state_e;
endpackage

// File: rtl/abd_rx_edge.sv
module abd_rx_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] shr;
  logic              prev;
  logic              cur;

  assign cur = shr[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      shr  <= '1;
      prev <= 1'b1;
    end else begin
      shr  <= {shr[STAGES-2:0], rx_in};
      prev <= cur;
    end
  end

  assign rise = cur & ~prev;
  assign fall = ~cur & prev;
endmodule

// File: rtl/abd_prescaler.sv
module abd_prescaler #(
  parameter int unsigned BASE_SLOW = 64,
  parameter int unsigned BASE_MID  = 16,
  parameter int unsigned BASE_FAST = 4,
  parameter int unsigned SCALE     = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic sel16,
  input  logic selhs,
  output logic tick
);
  localparam int unsigned DIV_MAX = BASE_SLOW * SCALE;
  localparam int unsigned PW      = $clog2(DIV_MAX);

  logic [PW-1:0] pre;
  logic [PW-1:0] lim;

  always_comb begin
    case ({sel16, selhs})
      2'b00:   lim = PW'(BASE_SLOW * SCALE - 1);
      2'b11:   lim = PW'(BASE_FAST * SCALE - 1);
      default: lim = PW'(BASE_MID * SCALE - 1);
    endcase
  end

  assign tick = run && (pre == lim);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre <= '0;
    end else if (run) begin
      pre <= tick ? '0 : pre + 1'b1;
    end
  end
endmodule

// File: rtl/abd_counter.sv
module abd_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load1,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (load1) begin
      cnt <= W'(1);
    end else if (inc) begin
      if (&cnt) ovf <= 1'b1;
      else      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_autobaud.sv
module uart_autobaud
  import abd_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BASE_SLOW   = 64,
  parameter int unsigned BASE_MID    = 16,
  parameter int unsigned BASE_FAST   = 4,
  parameter int unsigned SCALE       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_in,
  input  logic             start,
  input  logic             data_rd,
  input  logic             sel16,
  input  logic             selhs,
  output logic [CNT_W-1:0] divisor,
  output logic             ovf,
  output logic             done,
  output logic             en,
  output logic             rx_hold
);
  localparam int unsigned RISES = 5;
  localparam int unsigned EW    = $clog2(RISES + 1);

  abd_state_e    st;
  logic [EW-1:0] rises;
  logic          rise, fall, tick;
  logic          first_edge, last_edge, run;

  abd_rx_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .rx_in(rx_in), .rise(rise), .fall(fall)
  );

  assign first_edge = (st == ST_FIRST) && rise;
  assign last_edge  = (st == ST_MEAS) && rise && (rises == EW'(RISES - 1));
  assign run        = (st == ST_MEAS) && !last_edge;

  abd_prescaler #(
    .BASE_SLOW(BASE_SLOW), .BASE_MID(BASE_MID),
    .BASE_FAST(BASE_FAST), .SCALE(SCALE)
  ) u_pre (
    .clk(clk), .rst(rst), .clr(start || first_edge), .run(run),
    .sel16(sel16), .selhs(selhs), .tick(tick)
  );

  abd_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(start), .load1(first_edge),
    .inc(run && tick), .cnt(divisor), .ovf(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      rises   <= '0;
      en      <= 1'b0;
      rx_hold <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      st      <= ST_ARM;
      rises   <= '0;
      en      <= 1'b1;
      rx_hold <= 1'b1;
      done    <= 1'b0;
    end else begin
      case (st)
        ST_ARM:   if (fall) st <= ST_FIRST;
        ST_FIRST: if (rise) begin
          st    <= ST_MEAS;
          rises <= EW'(1);
        end
        ST_MEAS:  if (last_edge) begin
          st      <= ST_IDLE;
          en      <= 1'b0;
          rx_hold <= 1'b0;
        end else if (rise) begin
          rises <= rises + 1'b1;
        end
        default:  st <= ST_IDLE;
      endcase
      if (last_edge)    done <= 1'b1;
      else if (data_rd) done <= 1'b0;
    end
  end
endmodule

// File: rtl/abd_checker.sv
module abd_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         data_rd,
  input logic [W-1:0] divisor,
  input logic         ovf,
  input logic         done,
  input logic         en,
  input logic         rx_hold
);
  a_r4_end_sets_done: assert property (@(posedge clk) disable iff (rst)
    (!$past(start) && $fell(en)) |-> done);

  a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done && !data_rd && !start) |=> done);

  a_r6_hold_follows_en: assert property (@(posedge clk) disable iff (rst)
    rx_hold == en);

  a_r7_saturated: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (divisor == {W{1'b1}}));

  a_r3_frozen_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!en && !start) |=> $stable(divisor));

  a_r8_restart_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (divisor == '0 && !done && !ovf && en));
endmodule

bind uart_autobaud abd_checker #(.W(CNT_W)) u_abd_chk (
  .clk(clk), .rst(rst), .start(start), .data_rd(data_rd),
  .divisor(divisor), .ovf(ovf), .done(done), .en(en), .rx_hold(rx_hold)
);

// File: tb/test_uart_autobaud.sv
`timescale 1ns/1ps
module test_uart_autobaud;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx = 1'b1;
  logic start = 1'b0, data_rd = 1'b0, sel16 = 1'b0, selhs = 1'b0;
  logic [15:0] div_w;
  logic [7:0]  div_n;
  logic ovf_w, done_w, en_w, hold_w, ovf_n, done_n, en_n, hold_n;
  int n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  uart_autobaud i_uart_autobaud (
    .clk(clk), .rst(rst), .rx_in(rx), .start(start), .data_rd(data_rd),
    .sel16(sel16), .selhs(selhs), .divisor(div_w), .ovf(ovf_w),
    .done(done_w), .en(en_w), .rx_hold(hold_w)
  );

  uart_autobaud #(.CNT_W(8)) i_uart_autobaud_narrow (
    .clk(clk), .rst(rst), .rx_in(rx), .start(start), .data_rd(data_rd),
    .sel16(sel16), .selhs(selhs), .divisor(div_n), .ovf(ovf_n),
    .done(done_n), .en(en_n), .rx_hold(hold_n)
  );

  // behavioural reference model
  int    m_st = 0, m_cyc = 0, m_edges = 0;
  longint m_raw = 0;
  bit    m_s1 = 1, m_s2 = 1, m_pv = 1, m_en = 0, m_done = 0;

  function automatic int tick_div();
    case ({sel16, selhs})
      2'b00:   return 512;
      2'b11:   return 32;
      default: return 128;
    endcase
  endfunction

  always @(posedge clk) begin
    bit rise, fall, fin;
    rise = m_s2 && !m_pv;
    fall = !m_s2 && m_pv;
    fin  = 0;
    if (rst) begin
      m_st = 0; m_raw = 0; m_en = 0; m_done = 0;
      m_s1 = 1; m_s2 = 1; m_pv = 1;
    end else begin
      if (start) begin
        m_st = 1; m_raw = 0; m_en = 1; m_done = 0; m_edges = 0;
      end else begin
        case (m_st)
          1: if (fall) m_st = 2;
          2: if (rise) begin m_st = 3; m_raw = 1; m_cyc = 0; m_edges = 1; end
          3: if (rise && m_edges == 4) begin
               fin = 1; m_st = 0; m_en = 0;
             end else begin
               if (rise) m_edges++;
               m_cyc++;
               if (m_cyc % tick_div() == 0) m_raw++;
             end
          default: ;
        endcase
        if (fin) m_done = 1;
        else if (data_rd) m_done = 0;
      end
      m_pv = m_s2; m_s2 = m_s1; m_s1 = rx;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R4 en", en_w, m_en);
      chk("R5 done", done_w, m_done);
      chk("R6 rx_hold", hold_w, m_en);
      chk("R1/R3 divisor", div_w, (m_raw > 65535) ? 65535 : m_raw);
      chk("R7 ovf", ovf_w, m_raw > 65535);
      chk("R7 narrow divisor", div_n, (m_raw > 255) ? 255 : m_raw);
      chk("R7 narrow ovf", ovf_n, m_raw > 255);
      chk("R4 narrow en", en_n, m_en);
      chk("R5 narrow done", done_n, m_done);
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic hold_rx(input logic v, input int n);
    rx = v;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send55(input int b);
    @(posedge clk); #1;
    hold_rx(1'b0, b);
    for (int i = 0; i < 8; i++) hold_rx(((8'h55 >> i) & 1) != 0, b);
    hold_rx(1'b1, b);
  endtask

  task automatic run_frame(input logic s16, input logic hs, input int b, input int base);
    int d;
    sel16 = s16; selhs = hs;
    pulse_start();
    repeat (4) @(posedge clk);
    send55(b);
    repeat (6) @(posedge clk);
    @(negedge clk);
    d = int'(div_w) - b / base;
    chk("R2 tolerance", (d >= -1 && d <= 1), 1);
    chk("R4 done after frame", done_w, 1);
    @(posedge clk); #1 data_rd = 1'b1;
    @(posedge clk); #1 data_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk("R10 reset en", en_w, 0);
    chk("R10 reset done", done_w, 0);
    chk("R10 reset hold", hold_w, 0);
    chk("R10 reset divisor", div_w, 0);
    chk("R10 reset ovf", ovf_w, 0);
    @(posedge clk); #1 rst = 1'b0;
    repeat (4) @(posedge clk);

    run_frame(1'b1, 1'b1, 64, 4);
    run_frame(1'b1, 1'b1, 40, 4);
    run_frame(1'b1, 1'b0, 160, 16);
    run_frame(1'b0, 1'b1, 320, 16);
    run_frame(1'b0, 1'b0, 640, 64);

    // R5: completion and read strobe in the same cycle
    sel16 = 1'b1; selhs = 1'b1;
    pulse_start();
    fork
      send55(48);
      begin
        repeat (48 * 8) @(posedge clk);
        #1 data_rd = 1'b1;
      end
    join
    repeat (10) @(posedge clk);
    #1 data_rd = 1'b0;
    @(negedge clk);
    chk("R5 done cleared by held read", done_w, 0);

    // R8: restart mid-frame
    pulse_start();
    fork
      send55(64);
      begin
        repeat (64 * 3 + 5) @(posedge clk);
        #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        chk("R8 restart divisor", div_w, 0);
        chk("R8 restart done", done_w, 0);
        chk("R8 restart en", en_w, 1);
      end
    join
    repeat (20) @(posedge clk);
    run_frame(1'b1, 1'b1, 56, 4);

    // R9 and R7: count beyond one byte with sel16 low
    run_frame(1'b0, 1'b1, 4800, 16);
    chk("R9 high byte nonzero", div_w[15:8] != 0, 1);
    chk("R7 narrow saturated ovf", ovf_n, 1);
    chk("R7 narrow saturated value", div_n, 255);

    repeat (4) @(posedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule